// File: doc/BRIEF.md
# Single-Bit Set, Clear and Test Unit

This unit executes the single-bit instructions of a 4-bit controller. Each instruction names one bit of one nibble and either forces that bit to 1, forces it to 0, or copies it (straight or inverted) into a one-bit status flag. The nibble can be a data-memory word, an I/O port word or the accumulator. The memory word is found through the HL pair or through a 4-bit direct address in the second opcode byte. The port is found through a 4-bit port number in the second byte, or through the L register alone, which supplies both a port in the upper group of four and the bit inside it.

Instructions arrive as two opcode bytes on a valid/ready channel. An instruction transfers on a clock edge where `inst_valid` and `inst_ready` are both high. The source holds the bytes steady while valid is high and ready is low. One-byte memory and accumulator forms execute in the transfer cycle itself. All port forms and all direct-address forms take two cycles: the unit keeps the decoded instruction, pulls `inst_ready` low for one cycle and executes in that second cycle. Memory and port reads are asynchronous. A set or clear reads the target word, changes one bit and writes the word back in the same execute cycle, with `done` marking it. The accumulator is only tested and is never written.

Top module: `bsc_unit`

## Requirements
- R1: Byte0 = 1111 00BB clears bit BB of RAM[HL]; 1111 01BB sets it. Both execute in the transfer cycle, so `done` and the write are high in that same cycle.
- R2: Byte0 = 1111 10BB loads the flag with the inverse of accumulator bit BB. Byte0 = 1111 11BB loads it with the inverse of bit BB of RAM[HL]. Both take one cycle and write nothing.
- R3: Byte0 = 0110 1100 acts on RAM at direct address byte1[3:0], bit byte1[5:4]. The action comes from byte1[7:6]: 00 is test-inverse, 01 is set, 10 is test-direct and 11 is clear. The form takes two cycles.
- R4: Byte0 = 0110 1101 acts on the port numbered byte1[3:0], with the same byte1[7:6] and [5:4] coding as R3. The form takes two cycles.
- R5: Byte0 = 0110 0000 clears, 0110 0010 sets and 0110 0001 inverse-tests a port bit. The port number is L[3:2]+4 and the bit index is L[1:0]. These forms take two cycles.
- R6: A test-inverse loads the flag with the complement of the chosen bit. A test-direct loads the flag with the bit itself.
- R7: Every set or clear leaves the flag at 1 after it executes.
- R8: A set or clear writes back the word it read, changed only in the chosen bit. Memory and port writes never occur in the same cycle.
- R9: After a two-cycle form transfers, `inst_ready` is low for exactly one cycle, and that cycle is the execute cycle. While `inst_valid` is low, nothing executes.
- R10: Any other byte0 transfers in one cycle and pulses `done`, writes nothing and leaves the flag unchanged.
- R11: After reset the flag is 0, `inst_ready` is 1 and no write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Opcode bytes are present |
| inst_ready | output | 1 | Unit can take an instruction this cycle |
| inst_b0 | input | 8 | First opcode byte |
| inst_b1 | input | 8 | Second opcode byte (ignored by one-byte forms) |
| acc | input | 4 | Accumulator value |
| hl | input | RAM_AW | HL pair used as memory address |
| l_reg | input | 4 | L register |
| ram_addr | output | RAM_AW | Memory word address (read and write) |
| ram_rdata | input | 4 | Asynchronous memory read data |
| ram_we | output | 1 | Memory write strobe |
| ram_wdata | output | 4 | Memory write data |
| port_addr | output | PORT_AW | Port number (read and write) |
| port_rdata | input | 4 | Asynchronous port read data |
| port_we | output | 1 | Port write strobe |
| port_wdata | output | 4 | Port write data |
| sf | output | 1 | Status flag |
| done | output | 1 | Instruction executes in this cycle |

## Verification
The bench builds the unit with RAM_AW = 6. A 64-word memory model then shows that the HL form reaches words above the 16 that a direct address can name, and that direct addresses are zero-extended instead of mixed with HL. PORT_AW and the L-form port base keep their defaults of 4 and 4, so every direct port 0 to 15 and every L-selected port 4 to 7 is reachable and the upper-group offset can be seen. A deterministic pseudo-random run mixes all form classes, including unrecognised bytes, back to back, so one-cycle and two-cycle forms follow one another and the stall is exercised.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int NIB_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    BOP_NONE,
    BOP_CLR,
    BOP_SET,
    BOP_TF,
    BOP_TT
  } bop_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_PORT,
    TGT_ACC
  } tgt_e;

  typedef struct packed {
    bop_e             op;
    tgt_e             tgt;
    logic [SEL_W-1:0] bitsel;
    logic             two_cyc;
  } bctl_t;

  function automatic bop_e map_wide_op(input logic [1:0] code);
    case (code)
      2'b00:   return BOP_TF;
      2'b01:   return BOP_SET;
      2'b10:   return BOP_TT;
      default: return BOP_CLR;
    endcase
  endfunction
endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int RAM_AW      = 8,
  parameter int PORT_AW     = 4,
  parameter int L_PORT_BASE = 4
) (
  input  logic [7:0]         b0,
  input  logic [7:0]         b1,
  input  logic [RAM_AW-1:0]  hl,
  input  logic [3:0]         l_reg,
  output bctl_t              ctl,
  output logic [RAM_AW-1:0]  ram_a,
  output logic [PORT_AW-1:0] port_a
);
  localparam logic [PORT_AW-1:0] LBASE = PORT_AW'(L_PORT_BASE);

  always_comb begin
    ctl.op      = BOP_NONE;
    ctl.tgt     = TGT_NONE;
    ctl.bitsel  = '0;
    ctl.two_cyc = 1'b0;
    ram_a       = hl;
    port_a      = PORT_AW'(b1[3:0]);
    if (b0[7:4] == 4'hF) begin
      ctl.bitsel = b0[1:0];
      case (b0[3:2])
        2'b00: begin ctl.op = BOP_CLR; ctl.tgt = TGT_RAM; end
        2'b01: begin ctl.op = BOP_SET; ctl.tgt = TGT_RAM; end
        2'b10: begin ctl.op = BOP_TF;  ctl.tgt = TGT_ACC; end
        default: begin ctl.op = BOP_TF; ctl.tgt = TGT_RAM; end
      endcase
    end else if (b0[7:1] == 7'b0110_110) begin
      ctl.two_cyc = 1'b1;
      ctl.bitsel  = b1[5:4];
      ctl.op      = map_wide_op(b1[7:6]);
      ctl.tgt     = b0[0] ? TGT_PORT : TGT_RAM;
      ram_a       = RAM_AW'(b1[3:0]);
    end else if (b0[7:2] == 6'b0110_00 && b0[1:0] != 2'b11) begin
      ctl.two_cyc = 1'b1;
      ctl.tgt     = TGT_PORT;
      ctl.bitsel  = l_reg[1:0];
      port_a      = PORT_AW'(l_reg[3:2]) + LBASE;
      case (b0[1:0])
        2'b00:   ctl.op = BOP_CLR;
        2'b01:   ctl.op = BOP_TF;
        default: ctl.op = BOP_SET;
      endcase
    end
  end
endmodule

// File: rtl/bsc_bitop.sv
module bsc_bitop
  import bsc_pkg::*;
(
  input  logic [NIB_W-1:0] din,
  input  logic [SEL_W-1:0] sel,
  input  bop_e             op,
  output logic [NIB_W-1:0] dout,
  output logic             flag,
  output logic             flag_we,
  output logic             is_wr
);
  for (genvar i = 0; i < NIB_W; i++) begin : g_lane
    logic hit;
    assign hit     = (sel == SEL_W'(i));
    assign dout[i] = !hit            ? din[i] :
                     (op == BOP_SET) ? 1'b1   :
                     (op == BOP_CLR) ? 1'b0   : din[i];
  end

  always_comb begin
    case (op)
      BOP_TF:           flag = ~din[sel];
      BOP_TT:           flag = din[sel];
      BOP_SET, BOP_CLR: flag = 1'b1;
      default:          flag = 1'b0;
    endcase
  end

  assign flag_we = (op != BOP_NONE);
  assign is_wr   = (op == BOP_SET) || (op == BOP_CLR);

  // R8: a modified word differs from its source in at most one lane
  always_comb begin
    p_one_lane_r8: assert ($countones(dout ^ din) <= 1)
      else $error("bitop changed more than one lane");
  end
endmodule

// File: rtl/bsc_unit.sv
module bsc_unit
  import bsc_pkg::*;
#(
  parameter int RAM_AW      = 8,
  parameter int PORT_AW     = 4,
  parameter int L_PORT_BASE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inst_valid,
  output logic               inst_ready,
  input  logic [7:0]         inst_b0,
  input  logic [7:0]         inst_b1,
  input  logic [NIB_W-1:0]   acc,
  input  logic [RAM_AW-1:0]  hl,
  input  logic [3:0]         l_reg,
  output logic [RAM_AW-1:0]  ram_addr,
  input  logic [NIB_W-1:0]   ram_rdata,
  output logic               ram_we,
  output logic [NIB_W-1:0]   ram_wdata,
  output logic [PORT_AW-1:0] port_addr,
  input  logic [NIB_W-1:0]   port_rdata,
  output logic               port_we,
  output logic [NIB_W-1:0]   port_wdata,
  output logic               sf,
  output logic               done
);
  bctl_t              dec_ctl, held_ctl, cur_ctl;
  logic [RAM_AW-1:0]  dec_ra, held_ra;
  logic [PORT_AW-1:0] dec_pa, held_pa;
  logic               busy, accept, exec_now;
  logic [NIB_W-1:0]   operand, result;
  logic               flag, flag_we, is_wr;

  bsc_decode #(
    .RAM_AW(RAM_AW), .PORT_AW(PORT_AW), .L_PORT_BASE(L_PORT_BASE)
  ) u_dec (
    .b0(inst_b0), .b1(inst_b1), .hl(hl), .l_reg(l_reg),
    .ctl(dec_ctl), .ram_a(dec_ra), .port_a(dec_pa)
  );

  assign inst_ready = !busy;
  assign accept     = inst_valid && inst_ready;
  assign exec_now   = busy || (accept && !dec_ctl.two_cyc);

  // Second-cycle state: decoded instruction held for one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      held_ctl <= '{op: BOP_NONE, tgt: TGT_NONE, bitsel: '0, two_cyc: 1'b0};
      held_ra  <= '0;
      held_pa  <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (accept && dec_ctl.two_cyc) begin
      busy     <= 1'b1;
      held_ctl <= dec_ctl;
      held_ra  <= dec_ra;
      held_pa  <= dec_pa;
    end
  end

  assign cur_ctl   = busy ? held_ctl : dec_ctl;
  assign ram_addr  = busy ? held_ra  : dec_ra;
  assign port_addr = busy ? held_pa  : dec_pa;

  always_comb begin
    case (cur_ctl.tgt)
      TGT_RAM:  operand = ram_rdata;
      TGT_PORT: operand = port_rdata;
      TGT_ACC:  operand = acc;
      default:  operand = '0;
    endcase
  end

  bsc_bitop u_bit (
    .din(operand), .sel(cur_ctl.bitsel), .op(cur_ctl.op),
    .dout(result), .flag(flag), .flag_we(flag_we), .is_wr(is_wr)
  );

  assign ram_we     = exec_now && is_wr && (cur_ctl.tgt == TGT_RAM);
  assign port_we    = exec_now && is_wr && (cur_ctl.tgt == TGT_PORT);
  assign ram_wdata  = result;
  assign port_wdata = result;
  assign done       = exec_now;

  always_ff @(posedge clk) begin
    if (!rst_n)                    sf <= 1'b0;
    else if (exec_now && flag_we)  sf <= flag;
  end

  // R9: a two-cycle transfer withdraws ready in the following cycle
  p_stall_after_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_ctl.two_cyc) |=> !inst_ready);
  // R9: the stall lasts a single cycle and that cycle executes
  p_stall_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_ready |=> inst_ready);
  p_stall_executes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_ready |-> done);
  // R7: a write of either kind leaves the flag at 1
  p_flag_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || port_we) |=> sf);
  // R8: never both stores in one cycle
  p_one_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && port_we));
  // R10: outside an execute cycle nothing is written and the flag holds
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!ram_we && !port_we));
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(sf));
endmodule

// File: tb/bsc_unit_bench.sv
module bsc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW     = 6;
  localparam int PORT_AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inst_valid = 1'b0;
  logic inst_ready;
  logic [7:0] inst_b0 = '0, inst_b1 = '0;
  logic [3:0] acc_i = '0;
  logic [RAM_AW-1:0] hl_i = '0;
  logic [3:0] l_i = '0;
  logic [RAM_AW-1:0] ram_addr;
  logic [3:0] ram_rdata, ram_wdata, port_rdata, port_wdata;
  logic ram_we, port_we, sf, done;
  logic [PORT_AW-1:0] port_addr;

  logic [3:0] ram_m  [0:(1<<RAM_AW)-1];
  logic [3:0] port_m [0:(1<<PORT_AW)-1];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic model_sf = 1'b0;

  typedef struct {
    bit         ram_we;
    bit         port_we;
    int         addr;
    logic [3:0] wdata;
    logic       exp_sf;
    string      req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_unit #(.RAM_AW(RAM_AW), .PORT_AW(PORT_AW), .L_PORT_BASE(4)) u_bsc_unit (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_b0(inst_b0), .inst_b1(inst_b1), .acc(acc_i), .hl(hl_i), .l_reg(l_i),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .port_addr(port_addr), .port_rdata(port_rdata), .port_we(port_we),
    .port_wdata(port_wdata), .sf(sf), .done(done)
  );

  assign ram_rdata  = ram_m[ram_addr];
  assign port_rdata = port_m[port_addr];

  always @(posedge clk) begin
    if (ram_we)  ram_m[ram_addr]   <= ram_wdata;
    if (port_we) port_m[port_addr] <= port_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: builds the expected outcome from the requirements and pushes it
  task automatic run_inst(input logic [7:0] b0, input logic [7:0] b1, input string req);
    int op, tgt, a, bi;
    bit two;
    logic [3:0] din, nd;
    exp_t e;
    @(negedge clk);
    while (!inst_ready) @(negedge clk);
    op = 0; tgt = 0; a = 0; bi = 0; two = 1'b0;   // op: 1 clr 2 set 3 tf 4 tt
    if (b0[7:4] == 4'hF) begin
      bi = int'(b0[1:0]);
      a  = int'(hl_i);
      case (b0[3:2])
        2'd0: begin op = 1; tgt = 1; end
        2'd1: begin op = 2; tgt = 1; end
        2'd2: begin op = 3; tgt = 3; end
        default: begin op = 3; tgt = 1; end
      endcase
    end else if (b0 == 8'h6C || b0 == 8'h6D) begin
      two = 1'b1;
      bi  = int'(b1[5:4]);
      a   = int'(b1[3:0]);
      tgt = (b0 == 8'h6D) ? 2 : 1;
      case (b1[7:6])
        2'd0: op = 3;
        2'd1: op = 2;
        2'd2: op = 4;
        default: op = 1;
      endcase
    end else if (b0 == 8'h60 || b0 == 8'h61 || b0 == 8'h62) begin
      two = 1'b1;
      tgt = 2;
      a   = int'(l_i[3:2]) + 4;
      bi  = int'(l_i[1:0]);
      op  = (b0 == 8'h60) ? 1 : (b0 == 8'h62) ? 2 : 3;
    end
    din = (tgt == 1) ? ram_m[a] : (tgt == 2) ? port_m[a] : (tgt == 3) ? acc_i : 4'h0;
    nd = din;
    if (op == 1) nd[bi] = 1'b0;
    if (op == 2) nd[bi] = 1'b1;
    e.ram_we  = (op == 1 || op == 2) && tgt == 1;
    e.port_we = (op == 1 || op == 2) && tgt == 2;
    e.addr    = a;
    e.wdata   = nd;
    e.exp_sf  = (op == 1 || op == 2) ? 1'b1 : (op == 3) ? ~din[bi] :
                (op == 4) ? din[bi] : model_sf;
    e.req     = req;
    model_sf  = e.exp_sf;
    q.push_back(e);
    inst_b0 = b0;
    inst_b1 = b1;
    inst_valid = 1'b1;
    @(negedge clk);
    inst_valid = 1'b0;
    check(inst_ready == !two, {req, " R9 ready after transfer"}, int'(inst_ready), int'(!two));
  endtask

  // Monitor: pops expectations as the design executes
  initial begin : monitor
    bit pend = 1'b0;
    logic pend_sf = 1'b0;
    string pend_req = "";
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (pend) begin
          check(sf === pend_sf, {pend_req, " flag"}, int'(sf), int'(pend_sf));
          pend = 1'b0;
        end
        if (done) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 done without a transfer", 1, 0);
          end else begin
            e = q.pop_front();
            check(ram_we == e.ram_we && port_we == e.port_we, {e.req, " write strobes"},
                  int'({ram_we, port_we}), int'({e.ram_we, e.port_we}));
            if (e.ram_we)
              check(int'(ram_addr) == e.addr && ram_wdata == e.wdata, {e.req, " R8 ram word"},
                    int'({ram_addr, ram_wdata}), (e.addr << 4) | int'(e.wdata));
            if (e.port_we)
              check(int'(port_addr) == e.addr && port_wdata == e.wdata, {e.req, " R8 port word"},
                    int'({port_addr, port_wdata}), (e.addr << 4) | int'(e.wdata));
            pend = 1'b1; pend_sf = e.exp_sf; pend_req = e.req;
          end
        end else if (ram_we || port_we) begin
          check(1'b0, "R10 write outside execute", 1, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] x;
    for (int i = 0; i < (1 << RAM_AW); i++) ram_m[i] = 4'((i * 7) % 16);
    for (int i = 0; i < (1 << PORT_AW); i++) port_m[i] = 4'((i * 3 + 5) % 16);
    repeat (3) @(posedge clk);
    #2;
    check(sf == 1'b0, "R11 flag at reset", int'(sf), 0);
    check(inst_ready == 1'b1, "R11 ready at reset", int'(inst_ready), 1);
    check(!ram_we && !port_we, "R11 no write at reset", int'({ram_we, port_we}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    acc_i = 4'b1010; hl_i = 6'd41; l_i = 4'b1110;
    repeat (4) begin
      @(negedge clk); #2;
      check(!done, "R9 idle without valid", int'(done), 0);
    end
    run_inst(8'hF2, 8'h00, "R1 clear RAM[HL] bit2");
    run_inst(8'hF4, 8'h00, "R1 set RAM[HL] bit0");
    run_inst(8'hF4, 8'h00, "R1 set already-set bit");
    run_inst(8'hF9, 8'h00, "R2 acc bit1 inverse");
    run_inst(8'hF8, 8'h00, "R2 acc bit0 inverse");
    run_inst(8'hFF, 8'h00, "R2 RAM[HL] bit3 inverse");
    run_inst(8'h6C, 8'b0010_0101, "R3 test-inverse y5 bit2");
    run_inst(8'h6C, 8'b0111_1111, "R3 set y15 bit3 R7");
    run_inst(8'h6C, 8'b1000_0011, "R3 test-direct y3 bit0 R6");
    run_inst(8'h6C, 8'b1101_0000, "R3 clear y0 bit1");
    run_inst(8'h6D, 8'b0000_0010, "R4 test-inverse p2 bit0 R6");
    run_inst(8'h6D, 8'b0110_1100, "R4 set p12 bit2 R7");
    run_inst(8'h6D, 8'b1011_0111, "R4 test-direct p7 bit3");
    run_inst(8'h6D, 8'b1101_1111, "R4 clear p15 bit1");
    run_inst(8'h61, 8'h00, "R5 L test-inverse p7 bit2");
    run_inst(8'h62, 8'h00, "R5 L set p7 bit2");
    run_inst(8'h61, 8'h00, "R5 L test after set");
    run_inst(8'h60, 8'h00, "R5 L clear p7 bit2");
    l_i = 4'b0001;
    run_inst(8'h62, 8'h00, "R5 L set p4 bit1");
    run_inst(8'h55, 8'hFF, "R10 unrecognised 55");
    run_inst(8'h63, 8'hFF, "R10 unrecognised 63");
    x = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      logic [7:0] b0, b1;
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      b1 = x[7:0];
      case (k % 5)
        0: b0 = {4'hF, x[11:8]};
        1: b0 = 8'h6C;
        2: b0 = 8'h6D;
        3: b0 = 8'h60 + 8'(x[3:0] % 3);
        default: b0 = {4'h3, x[3:0]};
      endcase
      acc_i = x[15:12];
      hl_i  = x[13:8];
      l_i   = x[11:8];
      run_inst(b0, b1, "R6 R8 mixed stream");
    end
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9 all transfers executed", q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule